// File: doc/BRIEF.md
# Double-Precision Reciprocal Seed Unit

This unit turns the upper 32-bit word of an IEEE-754 binary64 operand into a rough reciprocal. The result is meant as the starting value for a later iterative refinement, such as Newton-Raphson, that runs elsewhere in the datapath. The low 32 bits of the operand never enter the unit. The word it returns is again laid out as the upper word of a binary64 value. A constant zero low word is appended to it, so that a full 64-bit seed is also available.

The mantissa of the reciprocal comes from a table of segment start values and slopes, indexed by the leading mantissa bits. The next mantissa bits drive a linear interpolation inside the segment. The exponent is negated around twice the bias. Zeros, subnormals, infinities and NaNs are sorted out before that arithmetic. Results too small for a normal binary64 are flushed to signed zero.

Operands enter and results leave through valid/ready handshakes. A transfer happens on a rising edge where valid and ready are both high. The unit is a two-stage pipeline with one shared stall. The result side may hold `out_ready` low for any number of cycles. While it does, the presented result stays frozen and `in_ready` is low. No operand is dropped, duplicated or reordered. With `out_ready` held high, the unit accepts one operand per cycle.

Top module: `rcp_seed_unit`

## Requirements
- R1: The input word is decoded as sign in bit 31, an 11-bit exponent field in bits 30..20 and the 20 leading mantissa bits in bits 19..0. An exponent field of 0 marks zero or subnormal. An exponent field of 2047 marks infinity (mantissa field zero) or NaN (mantissa field non-zero).
- R2: For a normal operand whose reciprocal is not flushed, let x be the operand (input word over a zero low word) and y the 64-bit result. Then |x*y - 1| < 2^-11.
- R3: For a normal operand with exponent field e and mantissa field zero, the result is exact: exponent field 2046 - e and mantissa field zero. Otherwise the exponent field is 2045 - e.
- R4: The result sign equals the operand sign for every operand except NaN.
- R5: An operand with exponent field 0 (zero or subnormal) returns infinity with the operand's sign (0x7FF00000 or 0xFFF00000).
- R6: An infinite operand returns zero with the operand's sign (0x00000000 or 0x80000000).
- R7: Any NaN operand returns the quiet NaN word 0x7FF80000.
- R8: When the result exponent from R3 would be 0 or below, the result is a signed zero. This covers exponent field 2046, and exponent field 2045 with a non-zero mantissa field. Exponent field 2045 with a zero mantissa field gives 0x00100000.
- R9: `out_dbl[63:32]` equals `out_hi` and `out_dbl[31:0]` is zero.
- R10: With `out_ready` high, an operand accepted on one rising edge is presented with `out_valid` high after the following rising edge, and not before.
- R11: While `out_valid` is high and `out_ready` is low, `out_hi` holds its value and `in_ready` is low. Results leave in acceptance order, each exactly once.
- R12: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand word is present |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_hi | input | 32 | Upper word of the binary64 operand |
| out_valid | output | 1 | Result word is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_hi | output | 32 | Upper word of the reciprocal seed |
| out_dbl | output | 64 | Full 64-bit seed: `out_hi` over a zero low word |

## Verification
The bench builds the unit with its default 64-segment table and 8 interpolation bits. These values make the first segment reachable, where interpolation lands exactly on 2.0 and the mantissa must saturate. They also make the last segment reachable, where the value approaches 1.0 from above. The error bound is checked there and at interior points. The default widths also put the two largest exponent fields within reach of single vectors. This exercises the flush boundary on both sides, together with the smallest normal operand. Back-pressure is driven with a third operand waiting while two are held in the pipe.

// File: rtl/rcp_seed_pkg.sv
package rcp_seed_pkg;

  localparam int EXP_W    = 11;
  localparam int MAN_W    = 20;
  localparam int WORD_W   = 1 + EXP_W + MAN_W;
  localparam int EXP_BIAS = (1 << (EXP_W - 1)) - 1;
  // reciprocal exponent base: 2*bias - 1
  localparam int EXP_BASE = 2 * EXP_BIAS - 1;
  // interpolated value 2/m held with this many fraction bits
  localparam int SEED_FB  = MAN_W + 1;
  localparam int SEED_W   = SEED_FB + 2;

  typedef enum logic [1:0] {
    KIND_NUM,
    KIND_ZERO,
    KIND_INF,
    KIND_NAN
  } kind_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] expo;
    kind_e            kind;
    logic             fzero;
    logic [MAN_W-1:0] mant;
  } seed_stage_t;

endpackage

// File: rtl/rcp_seed_mant.sv
module rcp_seed_mant
  import rcp_seed_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int INT_W = 8
) (
  input  logic [MAN_W-1:0] frac_i,
  output logic [MAN_W-1:0] mant_o,
  output logic             fzero_o
);

  localparam int DEPTH  = 1 << IDX_W;
  localparam int NUM_SH = SEED_FB + 1 + IDX_W;
  localparam int PROD_W = SEED_W + INT_W;

  logic [SEED_W-1:0] base_t  [DEPTH];
  logic [SEED_W-1:0] slope_t [DEPTH];

  // segment g covers m in [1+g/DEPTH, 1+(g+1)/DEPTH); value stored is 2/m
  for (genvar g = 0; g < DEPTH; g++) begin : g_seg
    localparam logic [63:0] Y_LO = (64'd1 << NUM_SH) / 64'(DEPTH + g);
    localparam logic [63:0] Y_HI = (64'd1 << NUM_SH) / 64'(DEPTH + g + 1);
    assign base_t[g]  = Y_LO[SEED_W-1:0];
    assign slope_t[g] = SEED_W'(Y_LO - Y_HI);
  end

  logic [IDX_W-1:0]  idx;
  logic [INT_W-1:0]  part;
  logic [SEED_W-1:0] y;
  logic              sat;
  logic              round_up;

  assign idx  = frac_i[MAN_W-1 -: IDX_W];
  assign part = frac_i[MAN_W-1-IDX_W -: INT_W];

  always_comb begin
    y = SEED_W'(({base_t[idx], INT_W'(0)}
                 - PROD_W'(slope_t[idx]) * PROD_W'(part)) >> INT_W);
    // value must lie in [1,2); clamp just below 2 otherwise
    sat      = y[SEED_W-1] | ~y[SEED_W-2];
    round_up = y[0] & ~(&y[SEED_FB-1:1]);
    mant_o   = sat ? '1 : y[SEED_FB-1:1] + MAN_W'(round_up);
    fzero_o  = (frac_i == '0);
  end

endmodule

// File: rtl/rcp_seed_pack.sv
module rcp_seed_pack
  import rcp_seed_pkg::*;
(
  input  seed_stage_t       st_i,
  output logic [WORD_W-1:0] hi_o
);

  logic signed [EXP_W+1:0] e_res;

  always_comb begin
    e_res = (EXP_W+2)'(EXP_BASE) - $signed({2'b00, st_i.expo})
            + $signed({{(EXP_W+1){1'b0}}, st_i.fzero});
    unique case (st_i.kind)
      KIND_ZERO: hi_o = {st_i.sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      KIND_INF:  hi_o = {st_i.sign, {(WORD_W-1){1'b0}}};
      KIND_NAN:  hi_o = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
      default: begin
        if (e_res <= 0)
          hi_o = {st_i.sign, {(WORD_W-1){1'b0}}};
        else
          hi_o = {st_i.sign, e_res[EXP_W-1:0],
                  st_i.fzero ? {MAN_W{1'b0}} : st_i.mant};
      end
    endcase
  end

endmodule

// File: rtl/rcp_seed_unit.sv
module rcp_seed_unit
  import rcp_seed_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int INT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_hi,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_hi,
  output logic [2*WORD_W-1:0] out_dbl
);

  logic             advance;
  logic [EXP_W-1:0] in_exp;
  logic [MAN_W-1:0] in_frac;
  seed_stage_t      s1_next;
  seed_stage_t      s1;
  logic             s1_valid;
  logic [MAN_W-1:0] lut_mant;
  logic             lut_fzero;
  logic [WORD_W-1:0] packed_hi;

  assign advance  = ~out_valid | out_ready;
  assign in_ready = advance;
  assign in_exp   = in_hi[WORD_W-2 -: EXP_W];
  assign in_frac  = in_hi[MAN_W-1:0];

  rcp_seed_mant #(.IDX_W(IDX_W), .INT_W(INT_W)) u_mant (
    .frac_i  (in_frac),
    .mant_o  (lut_mant),
    .fzero_o (lut_fzero)
  );

  always_comb begin
    s1_next.sign  = in_hi[WORD_W-1];
    s1_next.expo  = in_exp;
    s1_next.fzero = lut_fzero;
    s1_next.mant  = lut_mant;
    if (in_exp == '0)      s1_next.kind = KIND_ZERO;
    else if (&in_exp)      s1_next.kind = lut_fzero ? KIND_INF : KIND_NAN;
    else                   s1_next.kind = KIND_NUM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1       <= '0;
    end else if (advance) begin
      s1_valid <= in_valid;
      if (in_valid) s1 <= s1_next;
    end
  end

  rcp_seed_pack u_pack (
    .st_i (s1),
    .hi_o (packed_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hi    <= '0;
    end else if (advance) begin
      out_valid <= s1_valid;
      if (s1_valid) out_hi <= packed_hi;
    end
  end

  assign out_dbl = {out_hi, {WORD_W{1'b0}}};

  // R11: presented result frozen while the consumer stalls
  p_hold_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hi));

  // R11: operand waiting in the first stage is neither lost nor replaced
  p_hold_s1_r11: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && out_valid && !out_ready |=> s1_valid && $stable(s1));

  // R5: zero or subnormal class turns into infinity
  p_zero_to_inf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    advance && s1_valid && s1.kind == KIND_ZERO
      |=> out_hi[WORD_W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}});

  // R7: NaN class gives the single quiet NaN word
  p_nan_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    advance && s1_valid && s1.kind == KIND_NAN
      |=> out_hi == {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}});

  // R4: sign travels unchanged for every non-NaN operand
  p_sign_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    advance && s1_valid && s1.kind != KIND_NAN |=> out_hi[WORD_W-1] == $past(s1.sign));

  // R10: an accepted operand occupies the first stage on the next cycle
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_valid);

endmodule

// File: tb/rcp_seed_unit_tb_top.sv
module rcp_seed_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_hi;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_hi;
  logic [63:0] out_dbl;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam real TOL = 1.0 / 2048.0;

  always #2 clk = ~clk;

  rcp_seed_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_hi     (in_hi),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_hi    (out_hi),
    .out_dbl   (out_dbl)
  );

  // {tag, tolerance mode, operand word, expected word}
  localparam int NV = 26;
  localparam logic [68:0] VEC [NV] = '{
    {4'd3, 1'b0, 32'h3FF00000, 32'h3FF00000},
    {4'd3, 1'b0, 32'h40000000, 32'h3FE00000},
    {4'd4, 1'b0, 32'hC0100000, 32'hBFD00000},
    {4'd3, 1'b0, 32'h3FE00000, 32'h40000000},
    {4'd3, 1'b0, 32'h00100000, 32'h7FD00000},
    {4'd8, 1'b0, 32'h7FD00000, 32'h00100000},
    {4'd8, 1'b0, 32'h7FD80000, 32'h00000000},
    {4'd8, 1'b0, 32'hFFE80000, 32'h80000000},
    {4'd8, 1'b0, 32'h7FE00000, 32'h00000000},
    {4'd5, 1'b0, 32'h00000000, 32'h7FF00000},
    {4'd5, 1'b0, 32'h80000000, 32'hFFF00000},
    {4'd1, 1'b0, 32'h000FFFFF, 32'h7FF00000},
    {4'd5, 1'b0, 32'h800ABCDE, 32'hFFF00000},
    {4'd6, 1'b0, 32'h7FF00000, 32'h00000000},
    {4'd6, 1'b0, 32'hFFF00000, 32'h80000000},
    {4'd7, 1'b0, 32'h7FF80000, 32'h7FF80000},
    {4'd7, 1'b0, 32'hFFF00001, 32'h7FF80000},
    {4'd2, 1'b1, 32'h3FF80000, 32'h00000000},
    {4'd2, 1'b1, 32'h400921FB, 32'h00000000},
    {4'd2, 1'b1, 32'hC05EDD2F, 32'h00000000},
    {4'd2, 1'b1, 32'h3FEFFFFF, 32'h00000000},
    {4'd2, 1'b1, 32'h4123ABCD, 32'h00000000},
    {4'd2, 1'b1, 32'hBF1A2B3C, 32'h00000000},
    {4'd2, 1'b1, 32'h3FF00001, 32'h00000000},
    {4'd2, 1'b1, 32'h40000040, 32'h00000000},
    {4'd2, 1'b1, 32'h3FFFFFFF, 32'h00000000}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk_word(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_tol(input string req, input logic [31:0] hi, input logic [63:0] res);
    real x, y, err;
    x   = $bitstoreal({hi, 32'h0});
    y   = $bitstoreal(res);
    err = x * y - 1.0;
    if (err < 0.0) err = -err;
    checks++;
    if (!(err < TOL)) begin
      errors++;
      $display("FAIL %s operand %h actual error %e expected below %e", req, hi, err, TOL);
    end
  endtask

  // one operand through an otherwise empty pipe; checks R10 timing and R9 packing
  task automatic send_one(input logic [31:0] hi, output logic [31:0] rhi, output logic [63:0] rdbl);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_hi     = hi;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R10 result early", out_valid, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk_bit("R10 result after second edge", out_valid, 1'b1);
    rhi  = out_hi;
    rdbl = out_dbl;
    chk_word("R9 low word", rdbl[31:0], 32'h0);
    chk_word("R9 upper word", rdbl[63:32], rhi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rhi, rpos;
    logic [63:0] rdbl;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_hi     = '0;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_bit("R12 out_valid in reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R12 out_valid after reset", out_valid, 1'b0);
    chk_bit("R12 in_ready after reset", in_ready, 1'b1);

    for (int i = 0; i < NV; i++) begin
      send_one(VEC[i][63:32], rhi, rdbl);
      if (VEC[i][64])
        chk_tol(tag_name(VEC[i][68:65]), VEC[i][63:32], rdbl);
      else
        chk_word(tag_name(VEC[i][68:65]), rhi, VEC[i][31:0]);
    end

    // R4: sign flip alone flips only the result sign
    send_one(32'h3FF80000, rpos, rdbl);
    send_one(32'hBFF80000, rhi, rdbl);
    chk_word("R4 negative mirror", rhi, {1'b1, rpos[30:0]});

    // R11: stall with two in flight and a third waiting
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_hi     = 32'h3FF00000;
    @(posedge clk);
    @(negedge clk);
    in_hi = 32'h40000000;
    @(posedge clk);
    @(negedge clk);
    in_hi = 32'h7FF00000;
    chk_bit("R11 first result present", out_valid, 1'b1);
    chk_word("R11 first result", out_hi, 32'h3FF00000);
    chk_bit("R11 input blocked", in_ready, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk_word("R11 held result", out_hi, 32'h3FF00000);
      chk_bit("R11 input still blocked", in_ready, 1'b0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R11 second result present", out_valid, 1'b1);
    chk_word("R11 second result", out_hi, 32'h3FE00000);
    @(posedge clk);
    @(negedge clk);
    chk_bit("R11 third result present", out_valid, 1'b1);
    chk_word("R11 third result", out_hi, 32'h00000000);
    @(posedge clk);
    @(negedge clk);
    chk_bit("R11 no duplicate", out_valid, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule